// File: doc/BRIEF.md
# Pin Bank Register Controller

This block gives software control over a bank of general-purpose pins through a small 32-bit register bus. Every pin owns two configuration words. The first holds the driven level, the sampled input level, the direction, the trigger mode bits for the interrupt logic and a two-bit use field. The use field picks between the pad's native function and software-driven GPIO. The second word holds the weak-pull selection and a switch that turns input sensing off.

Two bitmap inputs are set outside the block and are only read through the bus. The ownership map has 1 where this controller may use the pin and 0 where the pin is reserved. The other is a redirection map. In the bitmaps each 32-bit word covers 32 pins. From the configuration state the block drives, for each pin, the output enable, the output value, the pull-up and pull-down controls and the native/GPIO select. Pad inputs are synchronised, and the result is presented as the read-back level.

Top module: `pinbank_regctl`

## Requirements
- R1: After reset every pin is native use (use field 0), input direction, input sensing disabled, no pull, output level 0 and both trigger bits 0. A pin's first word therefore reads 0x00000004, its second word reads 0x00000004, and padOe, padGpioSel, padPullUp, padPullDn and padOut are all 0.
- R2: Pin n's first configuration word is at byte address 0x100 + 8n and its second word is at 0x104 + 8n. Address bits 1:0 are ignored. rdData shows the addressed word on the clock edge after a cycle with rdEn high, and holds it otherwise.
- R3: First-word fields are: bit 31 output level, bit 30 input level (read-only), bit 4 trigger select (1 level, 0 edge), bit 3 trigger invert, bit 2 direction (1 input, 0 output), bits 1:0 use (0 native, 1 GPIO, 2 and 3 stored as written). All other bits read 0. padOut, trigLevel and trigInv follow bits 31, 4 and 3.
- R4: padGpioSel of a pin is 1 exactly when its use field is 1.
- R5: padOe of a pin is 1 exactly when its use field is 1 and its direction bit is 0.
- R6: Second-word bits 1:0 set the pull: 1 asserts padPullDn, 2 asserts padPullUp, and 0 or 3 asserts neither. Second-word bit 2 set disables input sensing. All other bits read 0. padPullUp and padPullDn are never both 1 on a pin.
- R7: First-word bit 30 shows padIn after a two-flop synchroniser, and reads 0 while the pin's input sensing is disabled.
- R8: The ownership map is read at 0x00 + 4k and the redirection map at 0x10 + 4k. Pin n appears in word n/32 at bit n%32. Bits for pins at or beyond the pin count read 0, and writes to these words change nothing.
- R9: Reads of unmapped addresses, including configuration slots for pin indices at or beyond the pin count, return 0. Writes to them alter no pin.
- R10: Pin configuration changes only on a write to that pin's own words. A cycle without wrEn leaves every pad control unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the addressed word |
| rdEn | input | 1 | Read strobe; rdData loads on the next edge |
| addr | input | ADDR_W | Byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| ownMask | input | NUM_PINS | Externally set ownership map (1 = usable) |
| redirMask | input | NUM_PINS | Externally set redirection map |
| padIn | input | NUM_PINS | Asynchronous pad input levels |
| padOut | output | NUM_PINS | Driven output level per pin |
| padOe | output | NUM_PINS | Output enable per pin |
| padGpioSel | output | NUM_PINS | 1 = pad under GPIO control, 0 = native function |
| padPullUp | output | NUM_PINS | Weak pull-up enable |
| padPullDn | output | NUM_PINS | Weak pull-down enable |
| trigLevel | output | NUM_PINS | Trigger select to interrupt logic (1 level) |
| trigInv | output | NUM_PINS | Trigger invert to interrupt logic |

## Verification
The bench builds the block with its defaults: 95 pins and a 12-bit address. With these values the last bitmap word is only partly filled (31 valid bits), so the zero padding above pin 94 can be observed. Pin 94's words sit at 0x3F0 and 0x3F4, directly below the first unmapped slot at 0x3F8, so the boundary between the last valid pin and the unmapped space is covered from both sides. The 4-word bitmap window likewise contains one unused word at 0x0C that must read 0.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int WORD_W     = 32;
  localparam int CFG_BASE   = 256;   // first per-pin word
  localparam int OWN_BASE   = 0;     // ownership bitmap window
  localparam int REDIR_BASE = 16;    // redirection bitmap window
  localparam int MAP_LIMIT  = 32;    // end of the redirection window

  // first-word bit positions
  localparam int OUT_POS  = 31;
  localparam int IN_POS   = 30;
  localparam int TRIG_POS = 4;
  localparam int INV_POS  = 3;
  localparam int DIR_POS  = 2;

  // second-word bit positions
  localparam int NOSENSE_POS = 2;

  localparam logic [1:0] USE_GPIO  = 2'd1;
  localparam logic [1:0] PULL_DOWN = 2'd1;
  localparam logic [1:0] PULL_UP   = 2'd2;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic wrCfgA;
    logic wrCfgB;
    logic rdLoad;
    logic rdCfgA;
    logic rdCfgB;
    logic rdOwn;
    logic rdRedir;
  } regStrobe_t;

endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS   = 95,
  parameter int ADDR_W     = 12,
  parameter int PIN_W      = 7,
  parameter int WORD_IDX_W = 2
) (
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  output regStrobe_t            strobe,
  output logic [PIN_W-1:0]      pinIdx,
  output logic [WORD_IDX_W-1:0] wordIdx
);

  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;

  logic [ADDR_W-1:0] cfgOff;
  logic              inCfg;
  logic              pinOk;
  logic              ownOk;
  logic              redirOk;
  logic              wordInRange;
  logic              secondWord;

  assign cfgOff      = addr - ADDR_W'(CFG_BASE);
  assign inCfg       = (int'(addr) >= CFG_BASE);
  assign pinOk       = inCfg && (int'(cfgOff[ADDR_W-1:3]) < NUM_PINS);
  assign secondWord  = addr[2];
  assign wordInRange = (int'(addr[3:2]) < NUM_WORDS);
  assign ownOk       = (int'(addr) >= OWN_BASE) && (int'(addr) < REDIR_BASE) && wordInRange;
  assign redirOk     = (int'(addr) >= REDIR_BASE) && (int'(addr) < MAP_LIMIT) && wordInRange;

  assign pinIdx  = cfgOff[3 +: PIN_W];
  assign wordIdx = WORD_IDX_W'(addr[3:2]);

  always_comb begin
    strobe         = '0;
    strobe.wrCfgA  = wrEn && pinOk && !secondWord;
    strobe.wrCfgB  = wrEn && pinOk && secondWord;
    strobe.rdLoad  = rdEn;
    strobe.rdCfgA  = pinOk && !secondWord;
    strobe.rdCfgB  = pinOk && secondWord;
    strobe.rdOwn   = ownOk;
    strobe.rdRedir = redirOk;
  end

endmodule

// File: rtl/pinbank_datapath.sv
module pinbank_datapath
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS   = 95,
  parameter int PIN_W      = 7,
  parameter int WORD_IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic [PIN_W-1:0]      pinIdx,
  input  logic [WORD_IDX_W-1:0] wordIdx,
  input  logic [WORD_W-1:0]     wrData,
  output logic [WORD_W-1:0]     rdData,
  input  logic [NUM_PINS-1:0]   ownMask,
  input  logic [NUM_PINS-1:0]   redirMask,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   padGpioSel,
  output logic [NUM_PINS-1:0]   padPullUp,
  output logic [NUM_PINS-1:0]   padPullDn,
  output logic [NUM_PINS-1:0]   trigLevel,
  output logic [NUM_PINS-1:0]   trigInv
);

  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int MAP_W     = NUM_WORDS * WORD_W;

  logic [NUM_PINS-1:0] outLvl;
  logic [NUM_PINS-1:0] trigSel;
  logic [NUM_PINS-1:0] trigNeg;
  logic [NUM_PINS-1:0] dirIn;
  logic [NUM_PINS-1:0] senseOff;
  logic [1:0]          useSel  [NUM_PINS];
  logic [1:0]          pullSel [NUM_PINS];

  logic [NUM_PINS-1:0] syncMeta;
  logic [NUM_PINS-1:0] syncQ;

  logic [MAP_W-1:0]    ownPad;
  logic [MAP_W-1:0]    redirPad;
  logic [WORD_W-1:0]   rdMux;

  // configuration storage, one pin per write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLvl   <= '0;
      trigSel  <= '0;
      trigNeg  <= '0;
      dirIn    <= '1;
      senseOff <= '1;
      for (int i = 0; i < NUM_PINS; i++) begin
        useSel[i]  <= '0;
        pullSel[i] <= '0;
      end
    end else begin
      if (strobe.wrCfgA) begin
        outLvl[pinIdx]  <= wrData[OUT_POS];
        trigSel[pinIdx] <= wrData[TRIG_POS];
        trigNeg[pinIdx] <= wrData[INV_POS];
        dirIn[pinIdx]   <= wrData[DIR_POS];
        useSel[pinIdx]  <= wrData[1:0];
      end
      if (strobe.wrCfgB) begin
        senseOff[pinIdx] <= wrData[NOSENSE_POS];
        pullSel[pinIdx]  <= wrData[1:0];
      end
    end
  end

  // two-flop input synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= '0;
      syncQ    <= '0;
    end else begin
      syncMeta <= padIn;
      syncQ    <= syncMeta;
    end
  end

  assign ownPad   = MAP_W'(ownMask);
  assign redirPad = MAP_W'(redirMask);

  always_comb begin
    rdMux = '0;
    if (strobe.rdCfgA) begin
      rdMux[OUT_POS]  = outLvl[pinIdx];
      rdMux[IN_POS]   = syncQ[pinIdx] & ~senseOff[pinIdx];
      rdMux[TRIG_POS] = trigSel[pinIdx];
      rdMux[INV_POS]  = trigNeg[pinIdx];
      rdMux[DIR_POS]  = dirIn[pinIdx];
      rdMux[1:0]      = useSel[pinIdx];
    end else if (strobe.rdCfgB) begin
      rdMux[NOSENSE_POS] = senseOff[pinIdx];
      rdMux[1:0]         = pullSel[pinIdx];
    end else if (strobe.rdOwn) begin
      rdMux = ownPad[int'(wordIdx)*WORD_W +: WORD_W];
    end else if (strobe.rdRedir) begin
      rdMux = redirPad[int'(wordIdx)*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdLoad) begin
      rdData <= rdMux;
    end
  end

  // pad-side controls, one slice per pin
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    logic isGpio;
    assign isGpio        = (useSel[p] == USE_GPIO);
    assign padGpioSel[p] = isGpio;
    assign padOe[p]      = isGpio && !dirIn[p];
    assign padPullDn[p]  = (pullSel[p] == PULL_DOWN);
    assign padPullUp[p]  = (pullSel[p] == PULL_UP);
  end

  assign padOut    = outLvl;
  assign trigLevel = trigSel;
  assign trigInv   = trigNeg;

endmodule

// File: rtl/pinbank_regctl.sv
module pinbank_regctl
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [NUM_PINS-1:0] ownMask,
  input  logic [NUM_PINS-1:0] redirMask,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padGpioSel,
  output logic [NUM_PINS-1:0] padPullUp,
  output logic [NUM_PINS-1:0] padPullDn,
  output logic [NUM_PINS-1:0] trigLevel,
  output logic [NUM_PINS-1:0] trigInv
);

  localparam int NUM_WORDS  = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int PIN_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int WORD_IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  regStrobe_t            strobe;
  logic [PIN_W-1:0]      pinIdx;
  logic [WORD_IDX_W-1:0] wordIdx;

  pinbank_decode #(
    .NUM_PINS  (NUM_PINS),
    .ADDR_W    (ADDR_W),
    .PIN_W     (PIN_W),
    .WORD_IDX_W(WORD_IDX_W)
  ) u_decode (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe),
    .pinIdx (pinIdx),
    .wordIdx(wordIdx)
  );

  pinbank_datapath #(
    .NUM_PINS  (NUM_PINS),
    .PIN_W     (PIN_W),
    .WORD_IDX_W(WORD_IDX_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pinIdx    (pinIdx),
    .wordIdx   (wordIdx),
    .wrData    (wrData),
    .rdData    (rdData),
    .ownMask   (ownMask),
    .redirMask (redirMask),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .padGpioSel(padGpioSel),
    .padPullUp (padPullUp),
    .padPullDn (padPullDn),
    .trigLevel (trigLevel),
    .trigInv   (trigInv)
  );

endmodule

// File: rtl/pinbank_regctl_chk.sv
module pinbank_regctl_chk #(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [31:0]         rdData,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] padGpioSel,
  input logic [NUM_PINS-1:0] padPullUp,
  input logic [NUM_PINS-1:0] padPullDn
);

  localparam int FIRST_FREE = 256 + 8 * NUM_PINS;

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && padGpioSel == '0 && padOut == '0));

  p_oe_needs_gpio_r5: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & ~padGpioSel) == '0);

  p_pull_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padPullDn) == '0);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) >= FIRST_FREE) |=> rdData == '0);

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(padOut) && $stable(padOe) && $stable(padGpioSel)
               && $stable(padPullUp) && $stable(padPullDn)));

endmodule

bind pinbank_regctl pinbank_regctl_chk #(
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .addr      (addr),
  .rdData    (rdData),
  .padOut    (padOut),
  .padOe     (padOe),
  .padGpioSel(padGpioSel),
  .padPullUp (padPullUp),
  .padPullDn (padPullDn)
);

// File: tb/pinbank_regctl_tb.sv
module pinbank_regctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 95;
  localparam int AW         = 12;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [31:0]   wr;
    logic [31:0]   exp;
  } vec_t;

  // write-then-read vectors
  localparam vec_t VECS [12] = '{
    '{12'h100, 32'hFFFF_FFFF, 32'h8000_001F},  // R3 pin 0 first word, bit 30 not writable
    '{12'h104, 32'hFFFF_FFFF, 32'h0000_0007},  // R6 pin 0 second word
    '{12'h3F0, 32'h0000_0009, 32'h0000_0009},  // R2 last pin first word
    '{12'h3F4, 32'h0000_0002, 32'h0000_0002},  // R2 last pin second word
    '{12'h3F8, 32'hFFFF_FFFF, 32'h0000_0000},  // R9 pin 95 slot
    '{12'h3FC, 32'hFFFF_FFFF, 32'h0000_0000},  // R9
    '{12'h080, 32'hFFFF_FFFF, 32'h0000_0000},  // R9 hole in map
    '{12'h008, 32'h0000_0000, 32'h7FFF_FFFF},  // R8 ownership word 2, partial
    '{12'h010, 32'hFFFF_FFFF, 32'h0000_0005},  // R8 redirection word 0
    '{12'h018, 32'h0000_0000, 32'h4000_0000},  // R8 redirection word 2
    '{12'h014, 32'hFFFF_FFFF, 32'h0000_0000},  // R8 redirection word 1
    '{12'h00C, 32'hFFFF_FFFF, 32'h0000_0000}   // R9 unused bitmap word
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NP-1:0] ownMask = '1;
  logic [NP-1:0] redirMask = (95'd1 << 94) | 95'd5;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut, padOe, padGpioSel, padPullUp, padPullDn, trigLevel, trigInv;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pinbank_regctl #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ownMask(ownMask), .redirMask(redirMask),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padGpioSel(padGpioSel),
    .padPullUp(padPullUp), .padPullDn(padPullDn), .trigLevel(trigLevel),
    .trigInv(trigInv)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    regRead(12'h118, d); check("R1 pin3 word A", d, 32'h0000_0004);
    regRead(12'h11C, d); check("R1 pin3 word B", d, 32'h0000_0004);
    check("R1 padOe", 32'(padOe != '0), 32'd0);
    check("R1 padGpioSel", 32'(padGpioSel != '0), 32'd0);
    check("R1 pulls", 32'((padPullUp | padPullDn) != '0), 32'd0);
    check("R1 padOut", 32'(padOut != '0), 32'd0);

    // table of vectors (R2 R3 R6 R8 R9)
    for (int v = 0; v < 12; v++) begin
      regWrite(VECS[v].addr, VECS[v].wr);
      regRead(VECS[v].addr, d);
      check($sformatf("R2/R8/R9 vector %0d", v), d, VECS[v].exp);
    end
    // R9 unmapped writes left the last pin alone
    regRead(12'h3F0, d); check("R9 pin94 A kept", d, 32'h0000_0009);
    regRead(12'h3F4, d); check("R9 pin94 B kept", d, 32'h0000_0002);
    // R8 bitmap writes ignored: ownership word 0 still all ones
    regWrite(12'h000, 32'h0);
    regRead(12'h000, d); check("R8 own word 0", d, 32'hFFFF_FFFF);

    // R5 R4 pin 5 GPIO output high
    regWrite(12'h128, 32'h8000_0001);
    @(negedge clk);
    check("R5 oe pin5", 32'(padOe[5]), 32'd1);
    check("R4 gpioSel pin5", 32'(padGpioSel[5]), 32'd1);
    check("R3 padOut pin5", 32'(padOut[5]), 32'd1);
    check("R10 other pins oe", 32'(padOe & ~(95'd1 << 5)), 32'd0);
    regRead(12'h130, d); check("R10 pin6 untouched", d, 32'h0000_0004);
    // R5 input direction drops enable
    regWrite(12'h128, 32'h8000_0005);
    @(negedge clk);
    check("R5 input dir oe", 32'(padOe[5]), 32'd0);
    // R4 native use with output dir
    regWrite(12'h128, 32'h8000_0000);
    @(negedge clk);
    check("R4 native gpioSel", 32'(padGpioSel[5]), 32'd0);
    check("R5 native oe", 32'(padOe[5]), 32'd0);
    // R4 use code 2 is not GPIO
    regWrite(12'h128, 32'h0000_0002);
    @(negedge clk);
    check("R4 use2 gpioSel", 32'(padGpioSel[5]), 32'd0);

    // R3 trigger bits
    regWrite(12'h128, 32'h0000_0010);
    @(negedge clk);
    check("R3 trigLevel", 32'(trigLevel[5]), 32'd1);
    check("R3 trigInv off", 32'(trigInv[5]), 32'd0);
    regWrite(12'h128, 32'h0000_0008);
    @(negedge clk);
    check("R3 trigInv on", 32'({trigLevel[5], trigInv[5]}), 32'd1);

    // R6 pull codes on pin 5
    regWrite(12'h12C, 32'h0000_0001);
    @(negedge clk);
    check("R6 code1", 32'({padPullUp[5], padPullDn[5]}), 32'd1);
    regWrite(12'h12C, 32'h0000_0002);
    @(negedge clk);
    check("R6 code2", 32'({padPullUp[5], padPullDn[5]}), 32'd2);
    regWrite(12'h12C, 32'h0000_0003);
    @(negedge clk);
    check("R6 code3", 32'({padPullUp[5], padPullDn[5]}), 32'd0);

    // R7 input sensing on pin 7
    regWrite(12'h13C, 32'h0000_0000);
    padIn[7] = 1'b1;
    padIn[8] = 1'b1;
    repeat (3) @(negedge clk);
    regRead(12'h138, d); check("R7 sensed high", d, 32'h4000_0004);
    regRead(12'h140, d); check("R7 pin8 sensing off", d, 32'h0000_0004);
    regWrite(12'h13C, 32'h0000_0004);
    regRead(12'h138, d); check("R7 sensing disabled", d, 32'h0000_0004);
    regWrite(12'h13C, 32'h0000_0000);
    padIn[7] = 1'b0;
    repeat (3) @(negedge clk);
    regRead(12'h138, d); check("R7 sensed low", d, 32'h0000_0004);

    // R2 address bits 1:0 ignored
    regRead(12'h3F3, d); check("R2 low addr bits", d, 32'h0000_0009);

    finished = 1;
    summary();
  end

endmodule